// File: doc/BRIEF.md
# Interleaved Three-Phase PWM Generator

This block drives three gate-enable signals for a bank of paralleled boost stages. One shared counter sets the switching period. Each channel compares its own on-time word with its own phase-shifted view of that counter, so the three pulses are spread across the period. Channel 1 is the master and always starts at the top of the period. The slots of the two slave channels depend on which channels are hard-enabled. With all three running they sit one third and two thirds of the way through the period. With one slave switched off, the remaining slave moves to the half-period point. Reducing a slave's on-time word, which is how a gain-based load share shows up here, never moves any slot.

Each channel has a cycle-by-cycle over-current flag from an external comparator. The flag is ignored for a fixed number of clock cycles at the start of every pulse, which hides the switching spike. After that window an asserted flag ends the pulse for the rest of that channel's period. The on-time is clamped so that every period keeps some off-time. All inputs except the over-current flags are captured only when a new period begins, so a change mid-period never cuts or stretches a pulse.

Top module: `tri_phase_pwm`

## Requirements
- R1: The period is P = max(periodIn, 16) clock cycles. periodStart is high for one cycle at the start of each period, every P cycles. periodIn, dutyIn and chEnIn are captured only in the cycle that ends a period, so a change made mid-period takes effect from the next period.
- R2: Channel 1 (index 0) has phase offset 0. Its gate rises in the cycle right after periodStart when its on-time is non-zero.
- R3: When all of chEnIn[2:0] are set, channel 2 has offset floor(P/3) and channel 3 has offset floor(2P/3). Gates are registered: a channel with offset F first shows high in cycle F+1, counting the periodStart cycle as cycle 0.
- R4: When chEnIn[2] is clear, channel 2 has offset floor(P/2).
- R5: When chEnIn[1] is clear, channel 3 has offset floor(P/2).
- R6: Offsets depend only on chEnIn. Changing the dutyIn words leaves every rise position unchanged.
- R7: A channel is high for min(duty, P - floor(P/32) - 1) cycles per period. A duty word of 0 gives no pulse.
- R8: A channel whose chEnIn bit is clear holds its gate low. When chEnIn[0] is clear, all three gates are low.
- R9: ocFlagIn[k] has no effect during the first BLANK_CYC cycles of channel k's pulse. The default of 25 equals 250 ns at 100 MHz.
- R10: ocFlagIn[k] seen high after the blanking window drives gate k low from the next cycle. The gate stays low for the rest of that channel's period, even if the flag drops, and the next period runs its full on-time.
- R11: While rstN is low, all gates and periodStart are low. periodStart is high in the cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodIn | input | CNT_W | Requested period in clock cycles |
| dutyIn | input | 3 x CNT_W | On-time in cycles, one word per channel |
| chEnIn | input | 3 | Hard enable per channel; bit 0 enables the whole block |
| ocFlagIn | input | 3 | Over-current comparator flag per channel |
| gateOut | output | 3 | Gate-enable outputs |
| periodStart | output | 1 | One-cycle strobe at the start of each period |

## Verification
The gate outputs are one register behind the channel's local count. A channel with offset F therefore rises in cycle F+1 after periodStart. An over-current flag sampled at a clock edge lowers the gate in the following cycle, and a new duty or enable value is first used in the period after the next periodStart. The bench applies each vector and lets one whole period pass after the capturing strobe. It then counts high cycles and locates rising edges over exactly P samples, taken at falling edges and starting at a strobe. The directed tests drive the flags and mid-period changes at falling edges of known cycle numbers and compare the totals for that period and the next.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_CH = 3;
  // off-time floor is P >> OFF_SHIFT plus one cycle (about 3 percent)
  localparam int OFF_SHIFT = 5;

  typedef struct packed {
    logic load;   // last cycle of the period: shadow registers capture
    logic start;  // first cycle of the new period
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int MIN_PER = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [CNT_W-1:0]               periodIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   dutyIn,
  input  logic [NUM_CH-1:0]              enIn,
  output pwmStrobe_t                     strobe,
  output logic [CNT_W-1:0]               cnt,
  output logic [CNT_W-1:0]               perSh,
  output logic [NUM_CH-1:0][CNT_W-1:0]   offSh,
  output logic [NUM_CH-1:0][CNT_W-1:0]   dutySh,
  output logic [NUM_CH-1:0]              enSh
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

  logic                         first;
  logic                         loadC;
  logic                         startQ;
  logic [CNT_W-1:0]             perNext;
  logic [CNT_W-1:0]             maxOn;
  logic [CNT_W-1:0]             third;
  logic [CNT_W-1:0]             rem3;
  logic [CNT_W-1:0]             twoThird;
  logic [CNT_W-1:0]             half;
  logic [NUM_CH-1:0][CNT_W-1:0] offNext;
  logic [NUM_CH-1:0][CNT_W-1:0] dutyNext;
  logic [NUM_CH-1:0]            enNext;

  // period limits and slot positions, evaluated once per period
  always_comb begin
    perNext  = (periodIn < MIN_P) ? MIN_P : periodIn;
    maxOn    = perNext - (perNext >> OFF_SHIFT) - ONE;
    third    = perNext / THREE;
    rem3     = perNext - third * THREE;
    twoThird = (third << 1) + ((rem3 == TWO) ? ONE : '0);
    half     = perNext >> 1;
    offNext[0] = '0;
    offNext[1] = enIn[2] ? third    : half;
    offNext[2] = enIn[1] ? twoThird : half;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_clamp
    assign dutyNext[k] = (dutyIn[k] > maxOn) ? maxOn : dutyIn[k];
    assign enNext[k]   = enIn[k] & enIn[0];
  end

  assign loadC  = first | (cnt == perSh - ONE);
  assign strobe = '{load: loadC, start: startQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      first  <= 1'b1;
      startQ <= 1'b0;
      cnt    <= '0;
      perSh  <= MIN_P;
      offSh  <= '0;
      dutySh <= '0;
      enSh   <= '0;
    end else begin
      first  <= 1'b0;
      startQ <= loadC;
      if (loadC) begin
        cnt    <= '0;
        perSh  <= perNext;
        offSh  <= offNext;
        dutySh <= dutyNext;
        enSh   <= enNext;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  AST_START_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ); // R1
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadC |=> ($stable(dutySh) && $stable(enSh) && $stable(offSh) && $stable(perSh))); // R1
  AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> ((dutySh[0] < perSh) && (dutySh[1] < perSh) && (dutySh[2] < perSh))); // R7
  AST_SLOT_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> ((offSh[1] < perSh) && (offSh[2] < perSh) && (offSh[0] == '0))); // R3
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W     = 12,
  parameter int BLANK_CYC = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] perSh,
  input  logic [CNT_W-1:0] offSh,
  input  logic [CNT_W-1:0] dutySh,
  input  logic             enSh,
  input  logic             ocFlag,
  output logic             gate
);
  localparam logic [CNT_W-1:0] BLANK_L = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] lc;
  logic             inBlank;
  logic             inOn;
  logic             ocLive;
  logic             trip;

  // local count: position inside this channel's own shifted period
  always_comb begin
    if (cnt >= offSh) lc = cnt - offSh;
    else              lc = cnt + (perSh - offSh);
    inBlank = lc < BLANK_L;
    inOn    = lc < dutySh;
    ocLive  = ocFlag & ~inBlank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trip <= 1'b0;
      gate <= 1'b0;
    end else begin
      trip <= (lc == '0) ? 1'b0 : (trip | (enSh & inOn & ocLive));
      gate <= enSh & inOn & ~ocLive & ~(trip & (lc != '0));
    end
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enSh |=> !gate); // R8
  AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (enSh && inOn && inBlank) |=> gate); // R9
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trip && (lc != '0)) |=> !gate); // R10
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BLANK_CYC = 25
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pwmStrobe_t                   strobe,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [CNT_W-1:0]             perSh,
  input  logic [NUM_CH-1:0][CNT_W-1:0] offSh,
  input  logic [NUM_CH-1:0][CNT_W-1:0] dutySh,
  input  logic [NUM_CH-1:0]            enSh,
  input  logic [NUM_CH-1:0]            ocFlag,
  output logic [NUM_CH-1:0]            gate
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_chan #(
      .CNT_W    (CNT_W),
      .BLANK_CYC(BLANK_CYC)
    ) i_chan (
      .clk   (clk),
      .rstN  (rstN),
      .cnt   (cnt),
      .perSh (perSh),
      .offSh (offSh[k]),
      .dutySh(dutySh[k]),
      .enSh  (enSh[k]),
      .ocFlag(ocFlag[k]),
      .gate  (gate[k])
    );
  end

  AST_MASTER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (gate[0] == $past(enSh[0] && (dutySh[0] != '0)))); // R2
  AST_MASTER_OFFTIME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !gate[0]); // R7
  AST_SYSTEM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enSh[0] |=> (gate == '0)); // R8
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int MIN_PER   = 16,
  parameter int BLANK_CYC = 25
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CNT_W-1:0]             periodIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0] dutyIn,
  input  logic [NUM_CH-1:0]            chEnIn,
  input  logic [NUM_CH-1:0]            ocFlagIn,
  output logic [NUM_CH-1:0]            gateOut,
  output logic                         periodStart
);
  pwmStrobe_t                   strobe;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             perSh;
  logic [NUM_CH-1:0][CNT_W-1:0] offSh;
  logic [NUM_CH-1:0][CNT_W-1:0] dutySh;
  logic [NUM_CH-1:0]            enSh;

  pwm_ctrl #(
    .CNT_W  (CNT_W),
    .MIN_PER(MIN_PER)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .periodIn(periodIn),
    .dutyIn  (dutyIn),
    .enIn    (chEnIn),
    .strobe  (strobe),
    .cnt     (cnt),
    .perSh   (perSh),
    .offSh   (offSh),
    .dutySh  (dutySh),
    .enSh    (enSh)
  );

  pwm_datapath #(
    .CNT_W    (CNT_W),
    .BLANK_CYC(BLANK_CYC)
  ) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .cnt   (cnt),
    .perSh (perSh),
    .offSh (offSh),
    .dutySh(dutySh),
    .enSh  (enSh),
    .ocFlag(ocFlagIn),
    .gate  (gateOut)
  );

  assign periodStart = strobe.start;
endmodule

// File: tb/test_tri_phase_pwm.sv
module test_tri_phase_pwm;
  localparam int CNT_W   = 12;
  localparam int MIN_PER = 16;
  localparam int BLANK   = 25;
  localparam int NV      = 10;

  typedef struct packed {
    logic [11:0] per;
    logic [11:0] d0;
    logic [11:0] d1;
    logic [11:0] d2;
    logic [2:0]  en;
    logic [2:0]  oc;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{12'd60, 12'd20,  12'd20, 12'd20, 3'b111, 3'b000},
    '{12'd60, 12'd20,  12'd10, 12'd5,  3'b111, 3'b000},
    '{12'd60, 12'd30,  12'd30, 12'd0,  3'b011, 3'b000},
    '{12'd60, 12'd30,  12'd0,  12'd30, 3'b101, 3'b000},
    '{12'd96, 12'd200, 12'd96, 12'd50, 3'b111, 3'b000},
    '{12'd90, 12'd0,   12'd45, 12'd45, 3'b111, 3'b000},
    '{12'd96, 12'd60,  12'd60, 12'd60, 3'b111, 3'b010},
    '{12'd5,  12'd4,   12'd4,  12'd4,  3'b111, 3'b000},
    '{12'd60, 12'd20,  12'd20, 12'd20, 3'b110, 3'b000},
    '{12'd60, 12'd20,  12'd20, 12'd20, 3'b001, 3'b000}
  };

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [CNT_W-1:0]      periodIn;
  logic [2:0][CNT_W-1:0] dutyIn;
  logic [2:0]            chEnIn;
  logic [2:0]            ocFlagIn;
  logic [2:0]            gateOut;
  logic                  periodStart;

  always #5 clk = ~clk;

  tri_phase_pwm #(.CNT_W(CNT_W), .MIN_PER(MIN_PER), .BLANK_CYC(BLANK)) i_tri_phase_pwm (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .dutyIn(dutyIn),
    .chEnIn(chEnIn), .ocFlagIn(ocFlagIn), .gateOut(gateOut), .periodStart(periodStart)
  );

  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;
  int   hiCnt [3];
  int   riseAt [3];
  int   spacingOk;
  logic [2:0] prevGate = 3'b000;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // returns at the falling edge of a cycle in which periodStart is high
  task automatic waitStart();
    forever begin
      @(negedge clk);
      if (periodStart) break;
      prevGate = gateOut;
    end
  endtask

  // called at cycle 0 of a period; samples P cycles and the next strobe
  task automatic measure(input int p);
    int extra = 0;
    for (int k = 0; k < 3; k++) begin hiCnt[k] = 0; riseAt[k] = -1; end
    for (int c = 0; c < p; c++) begin
      if (c > 0) begin
        @(negedge clk);
        if (periodStart) extra++;
      end
      for (int k = 0; k < 3; k++) begin
        if (gateOut[k]) hiCnt[k]++;
        if (gateOut[k] && !prevGate[k] && riseAt[k] < 0) riseAt[k] = c;
      end
      prevGate = gateOut;
    end
    @(negedge clk);
    spacingOk = (periodStart && extra == 0) ? 1 : 0;
  endtask

  function automatic int effPer(input int p);
    return (p < MIN_PER) ? MIN_PER : p;
  endfunction

  function automatic int effDuty(input int d, input int pe);
    int mx = pe - (pe / 32) - 1;
    return (d > mx) ? mx : d;
  endfunction

  function automatic int slot(input int k, input int pe, input logic [2:0] en);
    if (k == 0) return 0;
    if (k == 1) return en[2] ? pe / 3 : pe / 2;
    return en[1] ? (2 * pe) / 3 : pe / 2;
  endfunction

  function automatic string riseTag(input int v, input int k, input logic [2:0] en);
    if (k == 0) return "R2";
    if (v == 1) return "R6";
    if (!en[2]) return "R4";
    if (!en[1]) return "R5";
    return "R3";
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cntA;
    int pe;
    int de [3];
    logic [2:0] enEff;
    rstN     = 1'b0;
    periodIn = 12'd60;
    dutyIn   = '{12'd20, 12'd20, 12'd20};
    chEnIn   = 3'b111;
    ocFlagIn = 3'b000;

    // R11: reset state
    repeat (4) @(negedge clk);
    check("R11", "gates in reset", int'(gateOut), 0);
    check("R11", "strobe in reset", int'(periodStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "first strobe after release", int'(periodStart), 1);
    check("R11", "gates after release", int'(gateOut), 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      periodIn = VEC[v].per;
      dutyIn   = '{VEC[v].d2, VEC[v].d1, VEC[v].d0};
      chEnIn   = VEC[v].en;
      ocFlagIn = VEC[v].oc;
      pe       = effPer(int'(VEC[v].per));
      de[0]    = effDuty(int'(VEC[v].d0), pe);
      de[1]    = effDuty(int'(VEC[v].d1), pe);
      de[2]    = effDuty(int'(VEC[v].d2), pe);
      enEff    = VEC[v].en[0] ? VEC[v].en : 3'b000;
      waitStart();
      waitStart();
      measure(pe);
      check("R1", $sformatf("vec%0d period spacing", v), spacingOk, 1);
      for (int k = 0; k < 3; k++) begin
        int expCnt;
        int expRise;
        string cTag;
        if (!enEff[k]) begin expCnt = 0; cTag = "R8"; end
        else if (VEC[v].oc[k]) begin expCnt = (de[k] < BLANK) ? de[k] : BLANK; cTag = "R10"; end
        else begin expCnt = de[k]; cTag = "R7"; end
        expRise = (enEff[k] && de[k] > 0) ? slot(k, pe, VEC[v].en) + 1 : -1;
        check(cTag, $sformatf("vec%0d ch%0d high cycles", v, k + 1), hiCnt[k], expCnt);
        check(riseTag(v, k, VEC[v].en), $sformatf("vec%0d ch%0d rise cycle", v, k + 1), riseAt[k], expRise);
      end
    end

    // directed: R10 single flag pulse after blanking, then recovery
    periodIn = 12'd96;
    dutyIn   = '{12'd0, 12'd0, 12'd60};
    chEnIn   = 3'b001;
    ocFlagIn = 3'b000;
    waitStart();
    waitStart();
    cntA = 0;
    for (int c = 0; c < 96; c++) begin
      if (c > 0) @(negedge clk);
      if (gateOut[0]) cntA++;
      if (c == 40) ocFlagIn[0] = 1'b1;
      if (c == 41) ocFlagIn[0] = 1'b0;
    end
    check("R10", "pulse cut by late flag", cntA, 40);
    waitStart();
    measure(96);
    check("R10", "next period full on-time", hiCnt[0], 60);

    // directed: R9 flag held only inside the blanking window
    waitStart();
    cntA = 0;
    for (int c = 0; c < 96; c++) begin
      if (c > 0) @(negedge clk);
      if (gateOut[0]) cntA++;
      if (c == 1) ocFlagIn[0] = 1'b1;
      if (c == 25) ocFlagIn[0] = 1'b0;
    end
    check("R9", "flag inside blanking ignored", cntA, 60);

    // directed: R1 duty change mid-period waits for the next period
    waitStart();
    cntA = 0;
    for (int c = 0; c < 96; c++) begin
      if (c > 0) @(negedge clk);
      if (gateOut[0]) cntA++;
      if (c == 30) dutyIn[0] = 12'd10;
    end
    check("R1", "mid-period duty change not applied", cntA, 60);
    waitStart();
    measure(96);
    check("R1", "duty change applied next period", hiCnt[0], 10);

    // directed: R11 reset while running
    dutyIn = '{12'd60, 12'd60, 12'd60};
    chEnIn = 3'b111;
    waitStart();
    waitStart();
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R11", "gates low after reset mid-run", int'(gateOut), 0);
    check("R11", "strobe low after reset mid-run", int'(periodStart), 0);
    rstN = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule